// File: doc/BRIEF.md
# Configurable Asynchronous Character Transmitter

This block turns parallel characters into an asynchronous serial bit stream. A character written through the write strobe first lands in a one-entry holding register. When the shift engine is idle, the character moves into it. The engine then sends one start bit, the data bits least significant first, an optional parity bit, and the stop interval. All timing is counted in enable ticks at sixteen times the bit rate. The clock divider that produces those ticks lives outside the block.

The frame shape comes from a line-control byte. That byte sets the character size (5 to 8 bits), the parity mode (off, odd, even, or a constant stick value) and the stop length. A break control in the same byte holds the line at the spacing level. A loopback input sends the stream to an internal return path and parks the external line at idle. Two flags report whether the holding register is empty and whether the shift engine is empty, so the surrounding logic can keep the line busy with no gaps between characters.

Top module: `serial_char_tx`

## Requirements
- R1: `line_ctl[1:0]` selects the character size: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Each frame starts with one low start bit, followed by the data bits least significant first. Each of these bits lasts 16 ticks.
- R2: With `line_ctl[2]`=0 the stop interval is one high bit of 16 ticks. With `line_ctl[2]`=1 it is 32 ticks, or 24 ticks when the character size is 5 bits.
- R3: With `line_ctl[3]`=1 a parity bit follows the last data bit. It makes the count of ones over the data and parity bits even when `line_ctl[4]`=1, and odd when `line_ctl[4]`=0.
- R4: With `line_ctl[5]`=1 and `line_ctl[3]`=1 the parity bit is the constant NOT `line_ctl[4]`.
- R5: While `line_ctl[6]`=1 the serial stream is forced low in the same cycle, whatever the frame state.
- R6: A write clears `hold_empty` after the edge that captures it. When the shift engine is idle, the held character moves into the engine on the next edge, and `hold_empty` returns to 1.
- R7: `shift_empty` drops on the edge that loads a character. It returns to 1 exactly when the stop interval has been fully sent. That is the full frame tick count after the start bit appears.
- R8: A write while the holding register is full replaces the held character. The frame already being shifted goes on unchanged.
- R9: With `loop_en`=1 the stream appears on `loop_line` and `tx_line` stays high. With `loop_en`=0, `loop_line` stays high and the stream drives `tx_line`.
- R10: After reset both lines are high and both empty flags are 1.
- R11: A frame advances only on cycles with `tick16`=1. Without ticks the current bit is held and `shift_empty` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable at 16 times the bit rate |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| line_ctl | input | 8 | Frame format, parity and break control |
| loop_en | input | 1 | Route the stream to the internal return path |
| tx_line | output | 1 | External serial line, idle high |
| loop_line | output | 1 | Internal loopback stream, idle high |
| hold_empty | output | 1 | Holding register holds no character |
| shift_empty | output | 1 | Shift engine idle, last stop bit sent |

## Verification
A write captured at one clock edge is loaded into the shift engine at the next edge. The start bit therefore shows on the line one cycle after the write strobe is removed. With a tick on every cycle, data bit k sits on the line from 16(k+1) to 16(k+2)-1 cycles after the start bit appears. The bench samples each bit 8 cycles into its window, on the falling clock edge, counting cycles from the appearance of the start bit. `shift_empty` is checked as still 0 one cycle before the computed frame length and as 1 exactly at that length. Break and loopback act combinationally, so their checks sample at the next falling edge after the control changes.

// File: rtl/txs_pkg.sv
package txs_pkg;

  typedef struct packed {
    logic       brk;
    logic       stick;
    logic       even;
    logic       par_en;
    logic       long_stop;
    logic [1:0] wlen;
  } lcfg_t;

  function automatic lcfg_t decode_lc(input logic [7:0] b);
    lcfg_t c;
    c.wlen      = b[1:0];
    c.long_stop = b[2];
    c.par_en    = b[3];
    c.even      = b[4];
    c.stick     = b[5];
    c.brk       = b[6];
    return c;
  endfunction

endpackage

// File: rtl/txs_hold.sv
module txs_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] q
);

  logic          full_d;
  logic [DW-1:0] q_d;

  always_comb begin
    full_d = full;
    q_d    = q;
    if (take) full_d = 1'b0;
    if (wr_en) begin
      full_d = 1'b1;
      q_d    = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      q    <= '0;
    end else begin
      full <= full_d;
      q    <= q_d;
    end
  end

endmodule

// File: rtl/txs_framer.sv
module txs_framer
  import txs_pkg::*;
#(
  parameter int DW  = 8,
  parameter int TPB = 16,
  parameter int FW  = DW + 3,
  parameter int TCW = 8
) (
  input  lcfg_t          cfg,
  input  logic [DW-1:0]  data,
  output logic [FW-1:0]  frame,
  output logic [TCW-1:0] total
);

  int             nb;
  logic           par;
  logic [TCW-1:0] nbits;
  logic [TCW-1:0] stop_t;

  always_comb begin
    nb  = 5 + int'(cfg.wlen);
    par = 1'b0;
    for (int i = 0; i < DW; i++) begin
      if (i < nb) par = par ^ data[i];
    end
    if (!cfg.even) par = ~par;
    if (cfg.stick) par = ~cfg.even;

    frame    = '1;
    frame[0] = 1'b0;
    for (int j = 1; j < FW; j++) begin
      if (j <= nb) frame[j] = data[j-1];
      else if (cfg.par_en && j == nb + 1) frame[j] = par;
    end

    if (!cfg.long_stop)   stop_t = TCW'(TPB);
    else if (cfg.wlen == 2'b00) stop_t = TCW'(TPB + TPB / 2);
    else                  stop_t = TCW'(2 * TPB);

    nbits = TCW'(6) + TCW'(cfg.wlen) + TCW'(cfg.par_en);
    total = nbits * TCW'(TPB) + stop_t;
  end

endmodule

// File: rtl/txs_shift.sv
module txs_shift #(
  parameter int FW  = 11,
  parameter int TPB = 16,
  parameter int TCW = 8,
  localparam int PW = (TPB > 1) ? $clog2(TPB) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           load,
  input  logic [FW-1:0]  frame,
  input  logic [TCW-1:0] total,
  output logic           busy,
  output logic           bit_out
);

  logic [FW-1:0]  sr, sr_d;
  logic [PW-1:0]  phase, phase_d;
  logic [TCW-1:0] left, left_d;
  logic           busy_d;

  always_comb begin
    sr_d    = sr;
    phase_d = phase;
    left_d  = left;
    busy_d  = busy;
    if (load) begin
      sr_d    = frame;
      phase_d = '0;
      left_d  = total;
      busy_d  = 1'b1;
    end else if (busy && tick) begin
      if (phase == PW'(TPB - 1)) begin
        phase_d = '0;
        sr_d    = {1'b1, sr[FW-1:1]};
      end else begin
        phase_d = phase + 1'b1;
      end
      left_d = left - 1'b1;
      if (left == TCW'(1)) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr    <= '1;
      phase <= '0;
      left  <= '0;
      busy  <= 1'b0;
    end else begin
      sr    <= sr_d;
      phase <= phase_d;
      left  <= left_d;
      busy  <= busy_d;
    end
  end

  assign bit_out = busy ? sr[0] : 1'b1;

endmodule

// File: rtl/serial_char_tx.sv
module serial_char_tx
  import txs_pkg::*;
#(
  parameter int DW  = 8,
  parameter int TPB = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [7:0]    line_ctl,
  input  logic          loop_en,
  output logic          tx_line,
  output logic          loop_line,
  output logic          hold_empty,
  output logic          shift_empty
);

  localparam int FW  = DW + 3;
  localparam int TCW = $clog2(TPB * (DW + 4) + 1);

  logic [1:0]     rst_q;
  logic           rst_i;
  lcfg_t          cfg;
  logic           full;
  logic [DW-1:0]  held;
  logic           busy;
  logic           load;
  logic           bit_out;
  logic           stream;
  logic [FW-1:0]  frame;
  logic [TCW-1:0] total;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i = rst_q[1];

  assign cfg  = decode_lc(line_ctl);
  assign load = full && !busy;

  txs_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_i), .wr_en(wr_en), .wr_data(wr_data),
    .take(load), .full(full), .q(held)
  );

  txs_framer #(.DW(DW), .TPB(TPB), .FW(FW), .TCW(TCW)) u_framer (
    .cfg(cfg), .data(held), .frame(frame), .total(total)
  );

  txs_shift #(.FW(FW), .TPB(TPB), .TCW(TCW)) u_shift (
    .clk(clk), .rst_n(rst_i), .tick(tick16), .load(load),
    .frame(frame), .total(total), .busy(busy), .bit_out(bit_out)
  );

  assign stream      = cfg.brk ? 1'b0 : bit_out;
  assign tx_line     = loop_en ? 1'b1 : stream;
  assign loop_line   = loop_en ? stream : 1'b1;
  assign hold_empty  = !full;
  assign shift_empty = !busy;

endmodule

// File: rtl/serial_char_tx_chk.sv
module serial_char_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick16,
  input logic       wr_en,
  input logic [7:0] line_ctl,
  input logic       loop_en,
  input logic       tx_line,
  input logic       loop_line,
  input logic       hold_empty,
  input logic       shift_empty
);

  assert_loop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> tx_line);

  assert_loop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |-> loop_line);

  assert_break_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_ctl[6] && !loop_en) |-> !tx_line);

  assert_write_fills_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !hold_empty);

  assert_transfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_empty && shift_empty && !wr_en) |=> (hold_empty && !shift_empty));

  assert_load_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shift_empty) |-> $past(!hold_empty));

  assert_no_tick_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_empty && !tick16) |=> !shift_empty);

endmodule

bind serial_char_tx serial_char_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en),
  .line_ctl(line_ctl), .loop_en(loop_en), .tx_line(tx_line),
  .loop_line(loop_line), .hold_empty(hold_empty), .shift_empty(shift_empty)
);

// File: tb/serial_char_tx_tb.sv
`timescale 1ns/1ps
module serial_char_tx_tb;

  logic       clk;
  logic       rst_n;
  logic       tick16;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] line_ctl;
  logic       loop_en;
  logic       tx_line;
  logic       loop_line;
  logic       hold_empty;
  logic       shift_empty;

  int errors = 0;
  int checks = 0;

  serial_char_tx u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en),
    .wr_data(wr_data), .line_ctl(line_ctl), .loop_en(loop_en),
    .tx_line(tx_line), .loop_line(loop_line),
    .hold_empty(hold_empty), .shift_empty(shift_empty)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    chk(hold_empty == 1'b0, "R6", "hold_empty after write", int'(hold_empty), 0);
  endtask

  // Walks a frame; n counts falling edges, n=1 is the first with the start bit.
  task automatic observe(input logic [7:0] lc, input logic [7:0] d,
                         input logic lb, input int n0, input string req);
    int   nb, nsamp, total, stop_t, n;
    logic p;
    logic [11:0] e;
    logic line;
    nb = 5 + int'(lc[1:0]);
    p  = 1'b0;
    for (int i = 0; i < nb; i++) p = p ^ d[i];
    if (!lc[4]) p = ~p;
    if (lc[5]) p = ~lc[4];
    e = '1;
    e[0] = 1'b0;
    for (int i = 0; i < nb; i++) e[1+i] = d[i];
    if (lc[3]) e[1+nb] = p;
    nsamp  = 2 + nb + int'(lc[3]);
    stop_t = !lc[2] ? 16 : (lc[1:0] == 2'b00 ? 24 : 32);
    total  = 16 * (1 + nb + int'(lc[3])) + stop_t;
    n = n0;
    while (n < total + 1) begin
      @(negedge clk);
      n++;
      line = lb ? loop_line : tx_line;
      if (n == 1)
        chk(hold_empty == 1'b1, "R6", "hold_empty after transfer", int'(hold_empty), 1);
      if (n >= 9 && (n - 9) % 16 == 0 && (n - 9) / 16 < nsamp)
        chk(line == e[(n - 9) / 16], req, $sformatf("frame bit %0d", (n - 9) / 16),
            int'(line), int'(e[(n - 9) / 16]));
      if (lb && n == 9)
        chk(tx_line == 1'b1, "R9", "tx_line idle in loopback", int'(tx_line), 1);
      if (n == total)
        chk(shift_empty == 1'b0, "R7", "shift_empty before end", int'(shift_empty), 0);
      if (n == total + 1)
        chk(shift_empty == 1'b1, "R7", "shift_empty at end", int'(shift_empty), 1);
    end
  endtask

  task automatic send(input logic [7:0] lc, input logic [7:0] d,
                      input logic lb, input string req);
    line_ctl = lc;
    loop_en  = lb;
    do_write(d);
    observe(lc, d, lb, 0, req);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(tx_line == 1'b1, "R10", "tx_line after reset", int'(tx_line), 1);
    chk(loop_line == 1'b1, "R10", "loop_line after reset", int'(loop_line), 1);
    chk(hold_empty == 1'b1, "R10", "hold_empty after reset", int'(hold_empty), 1);
    chk(shift_empty == 1'b1, "R10", "shift_empty after reset", int'(shift_empty), 1);
  endtask

  task automatic t_break;
    line_ctl = 8'h43;
    loop_en  = 1'b0;
    @(negedge clk);
    chk(tx_line == 1'b0, "R5", "break forces low", int'(tx_line), 0);
    loop_en = 1'b1;
    @(negedge clk);
    chk(loop_line == 1'b0, "R5", "break on loop path", int'(loop_line), 0);
    chk(tx_line == 1'b1, "R9", "external idle during loop break", int'(tx_line), 1);
    line_ctl = 8'h03;
    loop_en  = 1'b0;
    @(negedge clk);
    chk(tx_line == 1'b1, "R5", "break released", int'(tx_line), 1);
  endtask

  task automatic t_overwrite;
    line_ctl = 8'h03;
    loop_en  = 1'b0;
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = 8'h5A;
    @(negedge clk);            // n=0 of first frame
    wr_data = 8'hC3;           // captured on the loading edge
    @(negedge clk);            // n=1
    wr_data = 8'h96;           // replaces 8'hC3
    @(negedge clk);            // n=2
    wr_en = 1'b0;
    chk(hold_empty == 1'b0, "R8", "holding full after overwrite", int'(hold_empty), 0);
    observe(8'h03, 8'h5A, 1'b0, 2, "R8");
    observe(8'h03, 8'h96, 1'b0, 0, "R8");
  endtask

  task automatic t_notick;
    line_ctl = 8'h03;
    loop_en  = 1'b0;
    tick16   = 1'b0;
    do_write(8'h81);
    @(negedge clk);            // n=1: loaded, start bit shown
    repeat (40) @(negedge clk);
    chk(tx_line == 1'b0, "R11", "start bit held without ticks", int'(tx_line), 0);
    chk(shift_empty == 1'b0, "R11", "busy held without ticks", int'(shift_empty), 0);
    tick16 = 1'b1;
    observe(8'h03, 8'h81, 1'b0, 1, "R11");
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    tick16   = 1'b1;
    wr_en    = 1'b0;
    wr_data  = 8'h00;
    line_ctl = 8'h03;
    loop_en  = 1'b0;
    t_reset();
    send(8'h03, 8'hA5, 1'b0, "R1");
    send(8'h02, 8'h4B, 1'b0, "R1");
    send(8'h04, 8'h1B, 1'b0, "R2");
    send(8'h07, 8'h6E, 1'b0, "R2");
    send(8'h1E, 8'h35, 1'b0, "R3");
    send(8'h09, 8'h2C, 1'b0, "R3");
    send(8'h3B, 8'hF1, 1'b0, "R4");
    send(8'h2B, 8'h0F, 1'b0, "R4");
    send(8'h03, 8'h3C, 1'b1, "R9");
    loop_en = 1'b0;
    @(negedge clk);
    chk(loop_line == 1'b1, "R9", "loop_line idle when off", int'(loop_line), 1);
    t_break();
    t_overwrite();
    t_notick();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule